// File: doc/BRIEF.md
# Rotating Core Identification Register

This block is a read-only identification word placed at the first address of a peripheral's register space. It is 16 bits wide. The one address returns four different words, one after another, and the sequence repeats. Between them the four words describe the core: its 8-bit identity, the interrupt line and lowest vector it uses, its version, the date of its last change, and how many interrupt vectors it owns.

Each returned word carries its own position in the sequence in the two top bits. Driver software can therefore read until it sees position 0, and then collect the remaining three words in order. No reset or side channel is needed to find the start.

Every field value is fixed when the design is built, through a parameter. Values that do not fit their field stop elaboration. The bus is a plain synchronous register interface: chip select, address, read strobe, write strobe and registered read data. Writes have no effect.

Top module: `core_ident_reg`

## Requirements
- R1: After reset, rd_data is 0x0000 and the sequence position is 0, so the first accepted read returns the position-0 word.
- R2: Each accepted read (rd_en high with cs high and addr equal to zero) moves the position to the next one, in the order 0, 1, 2, 3, then back to 0.
- R3: Bits 15:14 of every word returned by an accepted read hold the position that word was read from, coded as 2'b00, 2'b01, 2'b10 or 2'b11.
- R4: rd_data changes on the clock edge where an accepted read strobe is first seen. A strobe held high for several cycles counts as a single read. The strobe must drop for at least one cycle before the next read is counted.
- R5: Position-0 word layout: bit 13 is the interrupt line select (0 = first line, 1 = second line), bits 12:8 are the lowest vector number, and bits 7:0 are the core identity.
- R6: Bits 13:9 of the position-1 word hold the year minus 2000, bits 8:5 hold the major version, and bits 4:0 hold the minor version.
- R7: Position-2 word layout: bits 11:8 hold the month (1 to 12) and bits 4:0 hold the day (1 to 31). Bits 13:12 and 7:5 are zero.
- R8: Position-3 word layout: bits 3:0 hold the vector count minus one, where 0xF means no vectors. Bits 13:4 are zero.
- R9: Some bus activity does not change rd_data or the position: a read strobe with cs low, a read strobe with a nonzero address, and any write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the core |
| addr | input | ADDR_W | Word address within the core |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, ignored |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that a held read strobe keeps cs and addr steady for as long as it is high. A held read is treated as one read only under that condition. The stimulus meets these assumptions: it issues exactly one operation at a time, changes its inputs only on the falling clock edge, and always drops every strobe for at least one cycle before the next operation. The random mix covers hold lengths of one to three cycles, and it places reads to a wrong address, reads without chip select, and writes between the valid reads.

// File: rtl/core_ident_pkg.sv
package core_ident_pkg;
   localparam int DATA_W    = 16;
   localparam int TAG_W     = 2;
   localparam int NUM_WORDS = 4;
   localparam int BODY_W    = DATA_W - TAG_W;

   localparam int ID_W    = 8;
   localparam int LINE_W  = 1;
   localparam int VEC_W   = 5;
   localparam int YEAR_W  = 5;
   localparam int MAJ_W   = 4;
   localparam int MIN_W   = 5;
   localparam int MONTH_W = 4;
   localparam int DAY_W   = 5;
   localparam int NVEC_W  = 4;

   typedef logic [TAG_W-1:0]  pos_t;
   typedef logic [DATA_W-1:0] word_t;
   typedef logic [BODY_W-1:0] body_t;
endpackage

// File: rtl/core_ident_words.sv
module core_ident_words
   import core_ident_pkg::*;
#(
   parameter int CORE_ID    = 0,
   parameter int IRQ_LINE   = 0,
   parameter int IRQ_VEC    = 0,
   parameter int YEAR_OFS   = 0,
   parameter int VER_MAJOR  = 0,
   parameter int VER_MINOR  = 0,
   parameter int MONTH      = 1,
   parameter int DAY        = 1,
   parameter int NVEC_M1    = 15
) (
   output logic [NUM_WORDS-1:0][DATA_W-1:0] words_o
);
   localparam body_t BODY0 = body_t'({LINE_W'(IRQ_LINE), VEC_W'(IRQ_VEC), ID_W'(CORE_ID)});
   localparam body_t BODY1 = body_t'({YEAR_W'(YEAR_OFS), MAJ_W'(VER_MAJOR), MIN_W'(VER_MINOR)});
   localparam body_t BODY2 = body_t'({2'b00, MONTH_W'(MONTH), 3'b000, DAY_W'(DAY)});
   localparam body_t BODY3 = body_t'({10'd0, NVEC_W'(NVEC_M1)});

   // Elaboration-time range checks on every field value.
   if (CORE_ID < 0 || CORE_ID >= (1 << ID_W)) begin : g_bad_id
      $error("CORE_ID out of range");
   end
   if (IRQ_LINE < 0 || IRQ_LINE >= (1 << LINE_W)) begin : g_bad_line
      $error("IRQ_LINE out of range");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("IRQ_VEC out of range");
   end
   if (YEAR_OFS < 0 || YEAR_OFS >= (1 << YEAR_W)) begin : g_bad_year
      $error("YEAR_OFS out of range");
   end
   if (VER_MAJOR < 0 || VER_MAJOR >= (1 << MAJ_W)) begin : g_bad_major
      $error("VER_MAJOR out of range");
   end
   if (VER_MINOR < 0 || VER_MINOR >= (1 << MIN_W)) begin : g_bad_minor
      $error("VER_MINOR out of range");
   end
   if (MONTH < 1 || MONTH > 12) begin : g_bad_month
      $error("MONTH must be 1..12");
   end
   if (DAY < 1 || DAY > 31) begin : g_bad_day
      $error("DAY must be 1..31");
   end
   if (NVEC_M1 < 0 || NVEC_M1 >= (1 << NVEC_W)) begin : g_bad_nvec
      $error("NVEC_M1 out of range");
   end

   // Each word carries its own sequence position in the top bits.
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      body_t body;
      if (i == 0) begin : g_b0
         assign body = BODY0;
      end else if (i == 1) begin : g_b1
         assign body = BODY1;
      end else if (i == 2) begin : g_b2
         assign body = BODY2;
      end else begin : g_b3
         assign body = BODY3;
      end
      assign words_o[i] = {pos_t'(i), body};
   end
endmodule

// File: rtl/core_ident_seq.sv
module core_ident_seq
   import core_ident_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   output logic              accept_o,
   output pos_t              pos_o
);
   logic hit;
   logic hit_q;
   pos_t pos_q;

   assign hit      = cs && rd_en && (addr == '0);
   assign accept_o = hit && !hit_q;
   assign pos_o    = pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         pos_q <= '0;
      end else begin
         hit_q <= hit;
         if (accept_o) begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> pos_q == pos_t'($past(pos_q) + 1'b1)); // R2
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && pos_q == 2'b11) |=> pos_q == 2'b00); // R2
   AST_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(hit) && $past(rst_n)) |=> $stable(pos_q)); // R4
   AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(pos_q)); // R9
endmodule

// File: rtl/core_ident_reg.sv
module core_ident_reg
   import core_ident_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CORE_ID   = 0,
   parameter int IRQ_LINE  = 0,
   parameter int IRQ_VEC   = 0,
   parameter int YEAR_OFS  = 0,
   parameter int VER_MAJOR = 0,
   parameter int VER_MINOR = 0,
   parameter int MONTH     = 1,
   parameter int DAY       = 1,
   parameter int NVEC_M1   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [15:0]       rd_data
);
   logic [NUM_WORDS-1:0][DATA_W-1:0] words;
   logic  accept;
   pos_t  pos;
   word_t data_q;

   core_ident_words #(
      .CORE_ID(CORE_ID), .IRQ_LINE(IRQ_LINE), .IRQ_VEC(IRQ_VEC),
      .YEAR_OFS(YEAR_OFS), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR),
      .MONTH(MONTH), .DAY(DAY), .NVEC_M1(NVEC_M1)
   ) u_words (
      .words_o(words)
   );

   core_ident_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd_en(rd_en),
      .accept_o(accept), .pos_o(pos)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (accept) begin
         data_q <= words[pos];
      end
   end

   assign rd_data = data_q;

   AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rd_data[15:14] == $past(pos)); // R3
   AST_DATE_PADS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[15:14] == 2'b10) |-> (rd_data[13:12] == 2'b00 && rd_data[7:5] == 3'b000)); // R7
   AST_COUNT_PADS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[15:14] == 2'b11) |-> (rd_data[13:4] == '0)); // R8
   AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en) |=> $stable(rd_data)); // R9
endmodule

// File: tb/tb_core_ident_reg.sv
module tb_core_ident_reg;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int P_ID = 45, P_LINE = 1, P_VEC = 9, P_YEAR = 24;
   localparam int P_MAJ = 3, P_MIN = 17, P_MON = 11, P_DAY = 30, P_NV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic [AW-1:0] addr = '0;
   logic rd_en = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] rd_data;

   int nvec = 0;
   int nerr = 0;
   int bpos = 0;
   logic [15:0] last = 16'h0000;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_ident_reg #(
      .ADDR_W(AW), .CORE_ID(P_ID), .IRQ_LINE(P_LINE), .IRQ_VEC(P_VEC),
      .YEAR_OFS(P_YEAR), .VER_MAJOR(P_MAJ), .VER_MINOR(P_MIN),
      .MONTH(P_MON), .DAY(P_DAY), .NVEC_M1(P_NV)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr),
      .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data)
   );

   function automatic logic [15:0] exp_word(input int p);
      case (p)
         0: exp_word = {2'b00, 1'(P_LINE), 5'(P_VEC), 8'(P_ID)};        // R5
         1: exp_word = {2'b01, 5'(P_YEAR), 4'(P_MAJ), 5'(P_MIN)};       // R6
         2: exp_word = {2'b10, 2'b00, 4'(P_MON), 3'b000, 5'(P_DAY)};    // R7
         default: exp_word = {2'b11, 10'd0, 4'(P_NV)};                  // R8
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      nvec++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   // Valid read held for 'hold' cycles; data is checked after the first edge.
   task automatic do_read(input int hold, input string req);
      @(negedge clk);
      cs = 1'b1; addr = '0; rd_en = 1'b1;
      @(negedge clk);
      check(req, rd_data, exp_word(bpos));
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         check("R4 held", rd_data, exp_word(bpos));
      end
      rd_en = 1'b0; cs = 1'b0;
      last = exp_word(bpos);
      bpos = (bpos + 1) % 4;
   endtask

   task automatic do_ignored(input int kind);
      @(negedge clk);
      case (kind)
         0: begin cs = 1'b0; addr = '0; rd_en = 1'b1; end
         1: begin cs = 1'b1; addr = AW'(1 + ($urandom % 15)); rd_en = 1'b1; end
         default: begin cs = 1'b1; addr = '0; wr_en = 1'b1; end
      endcase
      @(negedge clk);
      cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0;
      @(negedge clk);
      check("R9 ignored op", rd_data, last);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R1 reset data", rd_data, 16'h0000);
      rst_n = 1'b1;
      // Directed: first pass through all four words, then wrap.
      do_read(1, "R1 R5 first word");
      do_read(1, "R6 word1");
      do_read(1, "R7 word2");
      do_read(1, "R8 word3");
      do_read(1, "R2 wrap to word0");
      check("R3 tag", {14'd0, rd_data[15:14]}, 16'd0);
      // Held strobe counts once.
      do_read(4, "R4 long hold");
      do_read(1, "R4 after hold");
      // Ignored operations, then confirm the position did not move.
      do_ignored(0);
      do_ignored(1);
      do_ignored(2);
      do_read(1, "R9 position kept");
      // Random mix.
      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom % 5;
         if (op < 2) begin
            do_read(1 + ($urandom % 3), "R2 random read");
            check("R3 random tag", {14'd0, rd_data[15:14]},
                  16'((bpos + 3) % 4));
         end else begin
            do_ignored(op - 2);
         end
      end
      // Reset mid-sequence returns to word 0.
      do_read(1, "R2 pre-reset");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset again", rd_data, 16'h0000);
      rst_n = 1'b1; bpos = 0;
      do_read(1, "R1 restart word0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule